// File: doc/BRIEF.md
# Double-Buffered Result Accumulator Bank

This block sits below a systolic matrix array and collects its column sums. Each result the array produces arrives as a whole row (one 32-bit value per array column) with a row index and a flag. The flag picks whether the value is added into the stored row or replaces it. Overwrite starts a new tile and accumulate adds further partial products to it.

The row storage has two equal halves. At any moment one half takes array results while the other half is read out. When the producer has finished a tile it raises a done strobe. The halves then swap roles as soon as the previous readout has completed. Until the swap, the input side holds its ready signal low. The half being read is streamed out one row per cycle, in ascending order. Each row goes through a fixed activation stage that adds a per-column bias, saturates to the signed 32-bit range and clamps negatives to zero. The results are written into an output buffer through a plain write port with a last marker.

The full-size bank has 4096 rows (two halves of 2048). The default parameters here scale this down and keep the two-way split.

Top module: `result_acc_bank`

## Requirements
- R1: After reset `inReady` is 1, `outValid` and `outLast` are 0, and every stored entry is zero.
- R2: A row accepted with `inAcc`=0 replaces all column entries of that row in the fill half with `inData` (column c in bits [32c+31:32c]).
- R3: A row accepted with `inAcc`=1 adds `inData` column by column to the stored entries. The addition wraps modulo 2^32.
- R4: Writes go only to the fill half. Rows being drained are never altered by writes made during the drain.
- R5: A `fillDone` pulse accepted while `inReady`=1 drops `inReady` from the next cycle on. The swap happens in the first cycle in which no drain is in progress. `inReady` returns to 1 at that swap.
- R6: After each swap the former fill half is drained exactly once, one row per cycle, in rows 0 to HALF_ROWS-1 order. Each drained row appears on `outAddr`.
- R7: `outLast` is 1 on the final drained row only, and never without `outValid`.
- R8: Each drained column value is max(0, entry + bias). The bias is the `biasIn` column value captured at the swap that started this drain.
- R9: When entry + bias exceeds 2^31-1 the output is 2^31-1. When it falls below -2^31 the output is 0.
- R10: Input rows presented while `inReady`=0 are ignored and do not change any stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Array result row present |
| inReady | output | 1 | Input side can accept rows and a done strobe |
| inRow | input | ROW_W | Row index within the fill half |
| inAcc | input | 1 | 1 = add to stored row, 0 = overwrite |
| inData | input | COLS*32 | Column sums, column c in bits [32c+31:32c] |
| fillDone | input | 1 | Fill half complete, request a swap |
| biasIn | input | COLS*32 | Per-column bias, held until the requested swap |
| outValid | output | 1 | Output buffer write strobe |
| outAddr | output | ROW_W | Row index of the drained row |
| outData | output | COLS*32 | Activated row |
| outLast | output | 1 | Final row of a drain |

## Verification
The hardest case to reach is a second done request that arrives while the previous half is still draining. In that window `inReady` must stay low, and rows offered must be dropped rather than written into the half that has not yet swapped. The stimulus reaches this window by writing only a couple of rows into the new fill half straight after a swap, then requesting the next swap while the eight-row drain is still running. It then offers junk rows on every stalled cycle. A scoreboard snapshot taken at each request detects any leaked write or early swap. The overflow corners are planted in one tile: a wrapping accumulate, a positive saturation and a negative overflow.

// File: rtl/accbank_pkg.sv
package accbank_pkg;
  localparam int ACC_W = 32;

  typedef struct packed {
    logic wrEn;
    logic wrAcc;
    logic fillSel;
    logic rdEn;
    logic rdLast;
    logic biasLoad;
  } bankStrobes_t;
endpackage

// File: rtl/accbank_act.sv
module accbank_act
  import accbank_pkg::*;
(
  input  logic [ACC_W-1:0] sumIn,
  input  logic [ACC_W-1:0] biasIn,
  output logic [ACC_W-1:0] actOut
);
  localparam logic signed [ACC_W:0] POS_MAX = {2'b00, {(ACC_W-1){1'b1}}};

  logic signed [ACC_W:0] wide;

  always_comb begin
    wide = $signed({sumIn[ACC_W-1], sumIn}) + $signed({biasIn[ACC_W-1], biasIn});
    if (wide > POS_MAX) actOut = POS_MAX[ACC_W-1:0];
    else if (wide[ACC_W]) actOut = '0;
    else actOut = wide[ACC_W-1:0];
  end
endmodule

// File: rtl/accbank_ctrl.sv
module accbank_ctrl
  import accbank_pkg::*;
#(
  parameter int HALF_ROWS = 8,
  parameter int ROW_W = $clog2(HALF_ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inAcc,
  input  logic             fillDone,
  output logic             inReady,
  output logic [ROW_W-1:0] rdRow,
  output bankStrobes_t     strb
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(HALF_ROWS - 1);

  logic             pendingSwap;
  logic             drainBusy;
  logic             fillSel;
  logic [ROW_W-1:0] drainRow;
  logic             swapNow;

  assign swapNow = pendingSwap && !drainBusy;
  assign inReady = !pendingSwap;
  assign rdRow   = drainRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingSwap <= 1'b0;
      drainBusy   <= 1'b0;
      fillSel     <= 1'b0;
      drainRow    <= '0;
    end else begin
      if (swapNow) pendingSwap <= 1'b0;
      else if (fillDone && inReady) pendingSwap <= 1'b1;

      if (swapNow) begin
        drainBusy <= 1'b1;
        drainRow  <= '0;
        fillSel   <= ~fillSel;
      end else if (drainBusy) begin
        if (drainRow == LAST_ROW) drainBusy <= 1'b0;
        else drainRow <= drainRow + ROW_W'(1);
      end
    end
  end

  always_comb begin
    strb.wrEn     = inValid && inReady;
    strb.wrAcc    = inAcc;
    strb.fillSel  = fillSel;
    strb.rdEn     = drainBusy;
    strb.rdLast   = drainBusy && (drainRow == LAST_ROW);
    strb.biasLoad = swapNow;
  end

  AST_STALL_WHILE_DRAINING: assert property (@(posedge clk) disable iff (!rstN)
    (pendingSwap && drainBusy) |=> !inReady); // R5
  AST_SWAP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fillSel) |-> !$past(drainBusy)); // R5
  AST_DRAIN_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (drainBusy && $past(drainBusy) && !$past(strb.rdLast)) |-> drainRow == $past(drainRow) + ROW_W'(1)); // R6
  AST_DRAIN_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drainBusy) |-> drainRow == '0); // R6
endmodule

// File: rtl/accbank_dp.sv
module accbank_dp
  import accbank_pkg::*;
#(
  parameter int COLS = 4,
  parameter int HALF_ROWS = 8,
  parameter int ROW_W = $clog2(HALF_ROWS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bankStrobes_t           strb,
  input  logic [ROW_W-1:0]       wrRow,
  input  logic [ROW_W-1:0]       rdRow,
  input  logic [COLS*ACC_W-1:0]  inData,
  input  logic [COLS*ACC_W-1:0]  biasIn,
  output logic                   outValid,
  output logic [ROW_W-1:0]       outAddr,
  output logic [COLS*ACC_W-1:0]  outData,
  output logic                   outLast
);
  logic [ACC_W-1:0] mem     [2][HALF_ROWS][COLS];
  logic [ACC_W-1:0] biasReg [COLS];
  logic [ACC_W-1:0] wrVal   [COLS];
  logic [ACC_W-1:0] rdVal   [COLS];
  logic [ACC_W-1:0] actVal  [COLS];
  logic             drainSel;

  assign drainSel = ~strb.fillSel;

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      wrVal[c] = strb.wrAcc ? mem[strb.fillSel][wrRow][c] + inData[c*ACC_W +: ACC_W]
                            : inData[c*ACC_W +: ACC_W];
      rdVal[c] = mem[drainSel][rdRow][c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int h = 0; h < 2; h++)
        for (int r = 0; r < HALF_ROWS; r++)
          for (int c = 0; c < COLS; c++)
            mem[h][r][c] <= '0;
    end else if (strb.wrEn) begin
      for (int c = 0; c < COLS; c++)
        mem[strb.fillSel][wrRow][c] <= wrVal[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < COLS; c++) biasReg[c] <= '0;
    end else if (strb.biasLoad) begin
      for (int c = 0; c < COLS; c++) biasReg[c] <= biasIn[c*ACC_W +: ACC_W];
    end
  end

  for (genvar g = 0; g < COLS; g++) begin : gCol
    accbank_act u_act (
      .sumIn (rdVal[g]),
      .biasIn(biasReg[g]),
      .actOut(actVal[g])
    );

    AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> !outData[g*ACC_W + ACC_W - 1]); // R8
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outAddr  <= '0;
      outData  <= '0;
    end else begin
      outValid <= strb.rdEn;
      outLast  <= strb.rdLast;
      outAddr  <= rdRow;
      for (int c = 0; c < COLS; c++) outData[c*ACC_W +: ACC_W] <= actVal[c];
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R7
  AST_NEXT_ROW_AFTER_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && !$past(outLast)) |-> outAddr == $past(outAddr) + ROW_W'(1)); // R6
endmodule

// File: rtl/result_acc_bank.sv
module result_acc_bank
  import accbank_pkg::*;
#(
  parameter int COLS = 4,
  parameter int ROWS = 16,
  localparam int HALF_ROWS = ROWS / 2,
  localparam int ROW_W = $clog2(HALF_ROWS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [ROW_W-1:0]      inRow,
  input  logic                  inAcc,
  input  logic [COLS*ACC_W-1:0] inData,
  input  logic                  fillDone,
  input  logic [COLS*ACC_W-1:0] biasIn,
  output logic                  outValid,
  output logic [ROW_W-1:0]      outAddr,
  output logic [COLS*ACC_W-1:0] outData,
  output logic                  outLast
);
  bankStrobes_t     strb;
  logic [ROW_W-1:0] rdRow;

  accbank_ctrl #(.HALF_ROWS(HALF_ROWS), .ROW_W(ROW_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inAcc   (inAcc),
    .fillDone(fillDone),
    .inReady (inReady),
    .rdRow   (rdRow),
    .strb    (strb)
  );

  accbank_dp #(.COLS(COLS), .HALF_ROWS(HALF_ROWS), .ROW_W(ROW_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrRow   (inRow),
    .rdRow   (rdRow),
    .inData  (inData),
    .biasIn  (biasIn),
    .outValid(outValid),
    .outAddr (outAddr),
    .outData (outData),
    .outLast (outLast)
  );

  AST_IGNORE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> !strb.wrEn); // R10
endmodule

// File: tb/result_acc_bank_tb.sv
module result_acc_bank_tb;
  localparam int COLS = 4;
  localparam int HALF = 8;
  localparam int RW = 3;
  localparam int DW = COLS * 32;

  typedef struct packed {
    logic [RW-1:0] addr;
    logic [DW-1:0] data;
    logic          last;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [RW-1:0] inRow = '0;
  logic          inAcc = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          fillDone = 1'b0;
  logic [DW-1:0] biasIn = '0;
  logic          outValid;
  logic [RW-1:0] outAddr;
  logic [DW-1:0] outData;
  logic          outLast;

  int checks = 0;
  int errors = 0;
  int benchFill = 0;
  logic [31:0] model [2][HALF][COLS];
  expItem_t expQ[$];

  always #4 clk = ~clk;

  result_acc_bank #(.COLS(COLS), .ROWS(2*HALF)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inRow(inRow),
    .inAcc(inAcc), .inData(inData), .fillDone(fillDone), .biasIn(biasIn),
    .outValid(outValid), .outAddr(outAddr), .outData(outData), .outLast(outLast)
  );

  function automatic logic [31:0] actRef(logic [31:0] s, logic [31:0] b);
    longint w;
    w = longint'($signed(s)) + longint'($signed(b));
    if (w > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (w < 0) return 32'h0;
    return w[31:0];
  endfunction

  task automatic check(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic putRow(int row, bit acc, logic [DW-1:0] d);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inRow = RW'(row); inAcc = acc; inData = d;
    for (int c = 0; c < COLS; c++)
      model[benchFill][row][c] = acc ? model[benchFill][row][c] + d[c*32 +: 32] : d[c*32 +: 32];
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic finishFill(logic [DW-1:0] b);
    expItem_t it;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    fillDone = 1'b1; biasIn = b;
    for (int r = 0; r < HALF; r++) begin
      it.addr = RW'(r);
      it.last = (r == HALF - 1);
      for (int c = 0; c < COLS; c++) it.data[c*32 +: 32] = actRef(model[benchFill][r][c], b[c*32 +: 32]);
      expQ.push_back(it);
    end
    benchFill ^= 1;
    @(negedge clk);
    fillDone = 1'b0;
  endtask

  // R10: offer junk on every stalled cycle; the scoreboard catches any leak
  task automatic stallJunk();
    while (!inReady) begin
      inValid = 1'b1; inRow = '0; inAcc = 1'b0; inData = {COLS{32'h5A5A_1234}};
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      expItem_t e;
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected drained row", DW'(outAddr), '0);
      end else begin
        e = expQ.pop_front();
        check(outAddr == e.addr, "R6 drain row order", DW'(outAddr), DW'(e.addr));
        check(outLast == e.last, "R7 last marker", DW'(outLast), DW'(e.last));
        check(outData == e.data, "R8/R9 R2 R3 R4 R10 activated data", outData, e.data);
      end
    end else if (rstN) begin
      if (outLast) check(1'b0, "R7 last without valid", DW'(outLast), '0);
    end
  end

  initial begin
    #(8 * 50000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] b1, b2, b3;
    for (int h = 0; h < 2; h++)
      for (int r = 0; r < HALF; r++)
        for (int c = 0; c < COLS; c++) model[h][r][c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready after reset", DW'(inReady), 1);
    check(outValid == 1'b0 && outLast == 1'b0, "R1 outputs idle after reset", DW'({outValid, outLast}), 0);

    // tile 1: overwrite (R2), accumulate with wrap (R3), saturation corners (R9)
    b1 = {32'hFFFF_FFFB, 32'h0000_0100, 32'hFFFF_FF00, 32'h0000_0007};
    for (int r = 0; r < HALF; r++)
      putRow(r, 1'b0, {32'(r*3+1), 32'(r*100), 32'(-r*50), 32'(r)});
    putRow(2, 1'b1, {32'd5, 32'd6, 32'd700, 32'd8});
    putRow(3, 1'b0, {4{32'hFFFF_FFFF}});
    putRow(3, 1'b1, {4{32'h0000_0002}});
    putRow(4, 1'b0, {32'd9, 32'h7FFF_FFF0, 32'd3, 32'h8000_0000});
    putRow(5, 1'b0, {32'd2, 32'd4, 32'h8000_0010, 32'd1});
    finishFill(b1);

    // tile 2: written while tile 1 drains (R4), then an early done request (R5)
    b2 = {32'd1, 32'd2, 32'd3, 32'd4};
    putRow(0, 1'b0, {32'd10, 32'd20, 32'd30, 32'd40});
    putRow(1, 1'b1, {32'd11, 32'd21, 32'd31, 32'd41});
    finishFill(b2);
    check(inReady == 1'b0, "R5 ready low while drain pending", DW'(inReady), 0);
    stallJunk();
    check(inReady == 1'b1, "R5 ready back after swap", DW'(inReady), 1);

    // tile 3: accumulate onto the contents left from tile 1 (R3)
    b3 = {32'h8000_0000, 32'h7FFF_FFFF, 32'd0, 32'hFFFF_FFFF};
    putRow(4, 1'b1, {32'd1, 32'd100, 32'd1, 32'd1});
    putRow(7, 1'b1, {32'd2, 32'd2, 32'd2, 32'd2});
    putRow(0, 1'b0, {32'd5, 32'd5, 32'd5, 32'd5});
    finishFill(b3);
    stallJunk();

    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R6 every expected row drained", DW'(expQ.size()), 0);
    check(inReady == 1'b1 && outValid == 1'b0, "R5 idle after drains", DW'({inReady, outValid}), 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule